// File: doc/BRIEF.md
# Bit-Serial All-One-Polynomial Field Multiplier

This block multiplies two elements of the binary extension field GF(2^M) whose modulus is the all-one polynomial P(x) = x^M + x^(M-1) + ... + x + 1. It works one multiplier bit per clock on a shift register of M+1 coefficients. Because P(x) divides x^(M+1) + 1, multiplying by x in that extended ring is a plain cyclic rotation, so the accumulator has no feedback taps at all. When the accumulation is finished, the block folds the extra top coefficient back into the M ordinary coefficients, one bit per clock. The product therefore leaves the block already reduced and in polynomial basis.

A client presents two operands with a one-cycle start strobe. After a fixed latency it gets a one-cycle done pulse with the product. The product register keeps its value until the next completion. A new operation may be started in the same cycle that done is high, so exponentiation, inversion or division sequencers can chain multiplications with no idle cycle. M is a parameter, and elaboration rejects any M for which the all-one polynomial is reducible (M+1 must be prime, with 2 of order M modulo M+1).

Top module: `gf_aop_mul`

## Requirements
- R1: While reset is asserted, and after it is released until the first completion, done_o is 0 and prod_o is all zeros.
- R2: At completion prod_o equals A·B mod P(x), where bit i of a_i, b_i and prod_o is the coefficient of x^i.
- R3: If start_i is high at a rising edge while the block is idle, then done_o is high in the cycle after the (2M+1)-th following rising edge, and low in every cycle before that.
- R4: done_o is high for exactly one clock cycle per operation.
- R5: a_i and b_i are sampled only on the edge that accepts start_i. A start_i pulse, or a change of a_i or b_i, while an operation is in progress has no effect on that operation's result or timing.
- R6: prod_o keeps the previous result unchanged while an operation is in progress, and changes only in the cycle that done_o rises.
- R7: A start_i held high in the cycle where done_o is high is accepted at the next edge, so back-to-back operations complete every 2M+2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising-edge active |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously to clk_i |
| start_i | input | 1 | Start strobe, accepted only while idle |
| a_i | input | M | Multiplicand, polynomial basis |
| b_i | input | M | Multiplier, polynomial basis |
| done_o | output | 1 | One-cycle completion pulse |
| prod_o | output | M | Reduced product, polynomial basis, held between completions |

## Verification
The M=4 field is swept over all 256 operand pairs, and the M=10 field is tested with the zero, one and all-ones elements plus random pairs, all against a long-division reference. Every run is back to back, so a design that could not accept a start in the done cycle would miss a completion. Operands are scrambled and a stray start is injected while busy. A design that re-sampled its inputs would return a wrong product, and one that restarted would fire done late. The fold of the top coefficient is exercised by products whose extended form has that coefficient set, such as all-ones times all-ones. A design that dropped the top coefficient instead of folding it would fail roughly half the pairs. The bench also checks that the old product holds just before each new done and that done falls after one cycle, which catches an output register that tracks the shifting value.

// File: rtl/gf_aop_pkg.sv
package gf_aop_pkg;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_MAC  = 2'd1,
    PH_CONV = 2'd2
  } phase_e;

  // True when 1 + x + ... + x^m is irreducible over GF(2):
  // m+1 prime and 2 has multiplicative order m modulo m+1.
  function automatic bit aop_irreducible(int m);
    int p;
    int r;
    bit ok;
    p  = m + 1;
    ok = (m >= 2);
    for (int d = 2; d < p; d++) begin
      if (p % d == 0) ok = 1'b0;
    end
    r = 1;
    for (int k = 1; k < m; k++) begin
      r = (r * 2) % p;
      if (r == 1) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/gf_aop_ctrl.sv
module gf_aop_ctrl
  import gf_aop_pkg::*;
#(
  parameter int M = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic load_o,
  output logic mac_o,
  output logic conv_o,
  output logic last_o,
  output logic busy_o,
  output logic done_o
);

  localparam int CW = $clog2(M + 1);
  localparam logic [CW-1:0] MAC_END  = CW'(M);
  localparam logic [CW-1:0] CONV_END = CW'(M - 1);

  phase_e        ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (start_i) begin
          ph_d  = PH_MAC;
          cnt_d = '0;
        end
      end
      PH_MAC: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == MAC_END) begin
          ph_d  = PH_CONV;
          cnt_d = '0;
        end
      end
      PH_CONV: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == CONV_END) begin
          ph_d  = PH_IDLE;
          cnt_d = '0;
        end
      end
      default: begin
        ph_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      done_q <= last_o;
    end
  end

  assign load_o = (ph_q == PH_IDLE) && start_i;
  assign mac_o  = (ph_q == PH_MAC);
  assign conv_o = (ph_q == PH_CONV);
  assign last_o = conv_o && (cnt_q == CONV_END);
  assign busy_o = (ph_q != PH_IDLE);
  assign done_o = done_q;

endmodule

// File: rtl/gf_aop_mac.sv
module gf_aop_mac #(
  parameter int M = 4
) (
  input  logic         clk_i,
  input  logic         load_i,
  input  logic         mac_i,
  input  logic         conv_i,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic         bit_o
);

  localparam int W = M + 1;

  logic [M-1:0] a_q;
  logic [W-1:0] bsh_q, bsh_d;
  logic [W-1:0] acc_q, acc_d;
  logic         en;

  // Horner over the extended multiplier, top coefficient first;
  // times x in the ring mod x^(M+1)+1 is a left rotation.
  always_comb begin
    acc_d = acc_q;
    bsh_d = bsh_q;
    if (load_i) begin
      acc_d = '0;
      bsh_d = {1'b0, b_i};
    end else if (mac_i) begin
      acc_d = {acc_q[M-1:0], acc_q[M]} ^ (bsh_q[M] ? {1'b0, a_q} : '0);
      bsh_d = {bsh_q[M-1:0], 1'b0};
    end else if (conv_i) begin
      acc_d = {acc_q[M], 1'b0, acc_q[M-1:1]};
    end
  end

  assign en = load_i | mac_i | conv_i;

  always_ff @(posedge clk_i) begin
    if (load_i) a_q <= a_i;
    if (en) begin
      acc_q <= acc_d;
      bsh_q <= bsh_d;
    end
  end

  // Fold the extended top coefficient into the current low coefficient.
  assign bit_o = acc_q[0] ^ acc_q[M];

endmodule

// File: rtl/gf_aop_unload.sv
module gf_aop_unload #(
  parameter int M = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         conv_i,
  input  logic         last_i,
  input  logic         bit_i,
  output logic [M-1:0] prod_o
);

  logic [M-2:0] sh_q, sh_d;
  logic [M-1:0] prod_q;

  generate
    if (M > 2) begin : g_wide
      assign sh_d = {bit_i, sh_q[M-2:1]};
    end else begin : g_narrow
      assign sh_d = bit_i;
    end
  endgenerate

  always_ff @(posedge clk_i) begin
    if (conv_i) sh_q <= sh_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prod_q <= '0;
    end else if (last_i) begin
      prod_q <= {bit_i, sh_q};
    end
  end

  assign prod_o = prod_q;

endmodule

// File: rtl/gf_aop_mul.sv
module gf_aop_mul #(
  parameter int M = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic [M-1:0] a_i,
  input  logic [M-1:0] b_i,
  output logic         done_o,
  output logic [M-1:0] prod_o
);

  generate
    if (!gf_aop_pkg::aop_irreducible(M)) begin : g_bad_field
      $error("gf_aop_mul: all-one polynomial of this degree is reducible");
    end
  endgenerate

  logic load, mac, conv, last, busy, fold_bit;

  gf_aop_ctrl #(.M(M)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .load_o (load),
    .mac_o  (mac),
    .conv_o (conv),
    .last_o (last),
    .busy_o (busy),
    .done_o (done_o)
  );

  gf_aop_mac #(.M(M)) u_mac (
    .clk_i (clk_i),
    .load_i(load),
    .mac_i (mac),
    .conv_i(conv),
    .a_i   (a_i),
    .b_i   (b_i),
    .bit_o (fold_bit)
  );

  gf_aop_unload #(.M(M)) u_unload (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .conv_i(conv),
    .last_i(last),
    .bit_i (fold_bit),
    .prod_o(prod_o)
  );

endmodule

// File: rtl/gf_aop_mul_chk.sv
module gf_aop_mul_chk #(
  parameter int M = 4
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         start_i,
  input logic [M-1:0] a_i,
  input logic [M-1:0] b_i,
  input logic         busy_i,
  input logic         done_i,
  input logic [M-1:0] prod_i
);

  localparam int CW = $clog2(2 * M + 3);
  localparam logic [CW-1:0] LAT = CW'(2 * M + 1);

  logic [CW-1:0] lat_q;
  logic [M-1:0]  ca_q, cb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lat_q <= '0;
      ca_q  <= '0;
      cb_q  <= '0;
    end else if (start_i && !busy_i) begin
      lat_q <= '0;
      ca_q  <= a_i;
      cb_q  <= b_i;
    end else if (busy_i) begin
      lat_q <= lat_q + 1'b1;
    end
  end

  function automatic logic [M-1:0] model(logic [M-1:0] x, logic [M-1:0] y);
    logic [M:0]   c;
    logic [M-1:0] r;
    c = '0;
    for (int i = 0; i < M; i++)
      for (int j = 0; j < M; j++)
        if (x[i] && y[j]) c[(i + j) % (M + 1)] = ~c[(i + j) % (M + 1)];
    for (int k = 0; k < M; k++) r[k] = c[k] ^ c[M];
    return r;
  endfunction

  a_r2_product: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> prod_i == model(ca_q, cb_q));

  // R5: a restart while busy would reset the count and delay done
  a_r3_latency: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> lat_q == LAT);

  a_r4_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |-> $stable(prod_i));

  a_r7_chain: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && start_i) |=> busy_i);

endmodule

bind gf_aop_mul gf_aop_mul_chk #(.M(M)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .start_i(start_i),
  .a_i    (a_i),
  .b_i    (b_i),
  .busy_i (busy),
  .done_i (done_o),
  .prod_i (prod_o)
);

// File: tb/tb_gf_aop_mul.sv
`timescale 1ns/1ps
module tb_gf_aop_mul;

  logic clk, rst_n;
  logic s4, s10, d4, d10;
  logic [3:0] a4, b4, p4;
  logic [9:0] a10, b10, p10;
  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [15:0] prev4 = '0;
  logic [15:0] prev10 = '0;

  initial clk = 1'b0;
  always #10 clk = ~clk;

  gf_aop_mul #(.M(4)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s4), .a_i(a4), .b_i(b4),
    .done_o(d4), .prod_o(p4));

  gf_aop_mul #(.M(10)) dut10 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s10), .a_i(a10), .b_i(b10),
    .done_o(d10), .prod_o(p10));

  // Carry-less product, then long division by the all-one polynomial
  function automatic logic [15:0] ref_mul(int m, logic [15:0] a, logic [15:0] b);
    logic [31:0] t;
    logic [31:0] poly;
    t = '0;
    poly = (32'd1 << (m + 1)) - 32'd1;
    for (int i = 0; i < m; i++) if (b[i]) t = t ^ (32'(a) << i);
    for (int d = 2 * m - 2; d >= m; d--) if (t[d]) t = t ^ (poly << (d - m));
    return t[15:0];
  endfunction

  task automatic chk(string req, bit ok, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(int m, bit s, logic [15:0] a, logic [15:0] b);
    if (m == 4) begin s4 = s; a4 = a[3:0]; b4 = b[3:0]; end
    else begin s10 = s; a10 = a[9:0]; b10 = b[9:0]; end
  endtask

  function automatic bit cur_done(int m);
    return (m == 4) ? d4 : d10;
  endfunction

  function automatic logic [15:0] cur_prod(int m);
    return (m == 4) ? {12'b0, p4} : {6'b0, p10};
  endfunction

  // Called just after an edge with the block idle or showing done.
  task automatic run_op(int m, logic [15:0] a, logic [15:0] b);
    logic [15:0] mask, exp_v, prev;
    bit early;
    mask  = 16'((32'd1 << m) - 1);
    exp_v = ref_mul(m, a & mask, b & mask);
    prev  = (m == 4) ? prev4 : prev10;
    early = 1'b0;
    drive(m, 1'b1, a, b);
    @(posedge clk); #1;
    drive(m, 1'b0, 16'($urandom), 16'($urandom));  // R5 scrambled operands
    for (int k = 1; k <= 2 * m; k++) begin
      if (k == 3) drive(m, 1'b1, ~a, ~b);            // R5 stray start
      if (k == 4) drive(m, 1'b0, 16'($urandom), 16'($urandom));
      @(posedge clk); #1;
      if (k == 1) chk("R4 done low after pulse", !cur_done(m), 16'(cur_done(m)), 16'd0);
      else if (cur_done(m)) early = 1'b1;
      if (k == 2 * m) chk("R6 previous product held", cur_prod(m) == prev, cur_prod(m), prev);
    end
    @(posedge clk); #1;
    chk("R3 R5 done timing", cur_done(m) && !early, 16'(cur_done(m)), 16'd1);
    chk("R2 product", cur_prod(m) == exp_v, cur_prod(m), exp_v);
    if (m == 4) prev4 = exp_v; else prev10 = exp_v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    drive(4, 1'b0, 16'd0, 16'd0);
    drive(10, 1'b0, 16'd0, 16'd0);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset m4", !d4 && p4 == 4'd0, {12'b0, p4}, 16'd0);
    chk("R1 reset m10", !d10 && p10 == 10'd0, {6'b0, p10}, 16'd0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 idle after release", !d4 && !d10 && p4 == 4'd0 && p10 == 10'd0,
        {6'b0, p10}, 16'd0);

    // R7: every operation is chained onto the previous done cycle
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++)
        run_op(4, 16'(a), 16'(b));
    @(posedge clk); #1;
    chk("R4 single pulse m4", !d4, {15'b0, d4}, 16'd0);

    run_op(10, 16'h3FF, 16'h3FF);
    run_op(10, 16'h000, 16'h2A5);
    run_op(10, 16'h001, 16'h1C3);
    run_op(10, 16'h200, 16'h200);
    run_op(10, 16'h3FF, 16'h001);
    for (int n = 0; n < 200; n++)
      run_op(10, 16'($urandom), 16'($urandom));
    @(posedge clk); #1;
    chk("R4 single pulse m10", !d10, {15'b0, d10}, 16'd0);
    repeat (3) @(posedge clk);
    #1;
    chk("R6 hold when idle", p10 == prev10[9:0], {6'b0, p10}, prev10);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule